// File: doc/BRIEF.md
# Dual-Mode LCD Scan Timing Generator

This block drives a 640 by 480 colour LCD panel. It counts clocks across each line and lines across each frame. From these counts it produces an active-low line sync, an active-low frame sync and a data-valid strobe, and it reports the column and row of the pixel on the data bus. It also passes an 18-bit pixel word to the panel bus. Inside that word, bits 17:12 are red, 11:6 are green and 5:0 are blue, and a higher value is brighter. The upstream pixel source sends words in raster order: left to right along a line, then top to bottom down the frame. The block forwards each word only while the visible window is open. At all other times the bus carries zero.

Two panel styles are supported. In fixed mode the first visible pixel comes 48 clocks after line sync ends, and the last visible pixel leaves 16 clocks of idle before the next line sync. The line is then 800 clocks long. In strobe mode two inputs set the idle gap after sync (the lead) and the gap before the next sync (the tail). These values are clamped to the ranges 4..48 and 2..16. The line length becomes sync plus lead plus 640 plus tail. The mode and both gaps are captured only where one frame ends and the next begins, so a frame never mixes two settings.

Top module: `lcd_timing_ctrl`

## Requirements
- R1: While `rst_n` is low, on each rising clock edge `hsync_n_o` and `vsync_n_o` go to 1, `de_o` goes to 0, and `rgb_o`, `col_o` and `row_o` go to 0. The first cycle after reset is column count 0 of line 0.
- R2: `hsync_n_o` is low for exactly H_SYNC (96) clocks at the start of every line. In fixed mode consecutive falling edges of `hsync_n_o` are 800 clocks apart.
- R3: `vsync_n_o` is low for the first V_SYNC (2) lines of a frame of V_SYNC+V_BACK+V_ACTIVE+V_FRONT lines (default 2+33+480+10 = 525). It changes only in the cycle in which `hsync_n_o` falls.
- R4: In fixed mode (`mode_en_i`=0), `de_o` rises exactly 48 clocks after `hsync_n_o` rises and stays high for 640 clocks. The next fall of `hsync_n_o` follows exactly 16 clocks later.
- R5: In strobe mode (`mode_en_i`=1), `de_o` rises exactly lead clocks after `hsync_n_o` rises and stays high for 640 clocks. The next fall of `hsync_n_o` follows exactly tail clocks later. The line is H_SYNC+lead+640+tail clocks long.
- R6: In strobe mode, a lead below 4 is used as 4 and a lead above 48 is used as 48. A tail below 2 is used as 2 and a tail above 16 is used as 16.
- R7: `de_o` stays 0 on every line outside the visible rows. Those rows are lines V_SYNC+V_BACK through V_SYNC+V_BACK+V_ACTIVE-1.
- R8: `rgb_o` equals the `pix_i` value present one clock earlier whenever `de_o` is 1, and `rgb_o` is 0 whenever `de_o` is 0.
- R9: While `de_o` is 1, `col_o` counts 0 to 639 across the line and `row_o` gives the visible row, 0 to V_ACTIVE-1. Both are 0 while `de_o` is 0.
- R10: `mode_en_i`, `lead_i` and `tail_i` are sampled during reset and at the clock that ends the last line of a frame. Changing them at any other time has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_en_i | input | 1 | 0 selects fixed mode, 1 selects strobe mode |
| lead_i | input | 6 | Strobe-mode gap from the end of line sync to the first pixel |
| tail_i | input | 5 | Strobe-mode gap from the last pixel to the next line sync |
| pix_i | input | 18 | Incoming pixel word (R 17:12, G 11:6, B 5:0) |
| hsync_n_o | output | 1 | Line sync, active low |
| vsync_n_o | output | 1 | Frame sync, active low |
| de_o | output | 1 | Data-valid strobe |
| col_o | output | 10 | Column of the pixel on `rgb_o` |
| row_o | output | 9 | Row of the pixel on `rgb_o` |
| rgb_o | output | 18 | Pixel word to the panel |

## Verification
The hardest case to reach is a settings change that arrives in the middle of a frame. The old timing must hold until the last line ends and the new timing must apply from the first line of the next frame. It takes full frames, so the bench builds the block with a short vertical total and keeps the real 640-pixel line. It changes mode and gaps a few thousand clocks into each frame, including out-of-range gaps that must clamp in both directions. A behavioural model then predicts every output on every clock across those frame boundaries.

// File: rtl/lcd_tc_pkg.sv
// Package: limits and the captured-setting type shared by the scan timing blocks.
// Assumes gap inputs are narrow unsigned values that are clamped before use.
package lcd_tc_pkg;

    localparam int LEAD_W     = 6;
    localparam int TAIL_W     = 5;
    localparam int FIX_LEAD   = 48;
    localparam int FIX_TAIL   = 16;
    localparam int LEAD_MIN   = 4;
    localparam int LEAD_MAX   = 48;
    localparam int TAIL_MIN   = 2;
    localparam int TAIL_MAX   = 16;

    typedef struct packed {
        logic [LEAD_W-1:0] lead;
        logic [TAIL_W-1:0] tail;
    } porch_t;

endpackage

// File: rtl/lcd_cfg_shadow.sv
// Captures the panel mode and gap lengths as one effective gap pair.
// Assumes load is high only on the last clock of a frame; reset also captures.
module lcd_cfg_shadow
    import lcd_tc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              mode_en_i,
    input  logic [LEAD_W-1:0] lead_i,
    input  logic [TAIL_W-1:0] tail_i,
    output porch_t            porch_o
);

    porch_t nxt;

    // Purpose: force a gap value into its legal window.
    function automatic logic [LEAD_W-1:0] fit_lead(input logic [LEAD_W-1:0] v);
        if (v < LEAD_W'(LEAD_MIN)) return LEAD_W'(LEAD_MIN);
        if (v > LEAD_W'(LEAD_MAX)) return LEAD_W'(LEAD_MAX);
        return v;
    endfunction

    function automatic logic [TAIL_W-1:0] fit_tail(input logic [TAIL_W-1:0] v);
        if (v < TAIL_W'(TAIL_MIN)) return TAIL_W'(TAIL_MIN);
        if (v > TAIL_W'(TAIL_MAX)) return TAIL_W'(TAIL_MAX);
        return v;
    endfunction

    // Purpose: pick fixed gaps or clamped programmed gaps.
    always_comb begin
        if (mode_en_i) begin
            nxt.lead = fit_lead(lead_i);
            nxt.tail = fit_tail(tail_i);
        end else begin
            nxt.lead = LEAD_W'(FIX_LEAD);
            nxt.tail = TAIL_W'(FIX_TAIL);
        end
    end

    // Purpose: hold the settings for a whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            porch_o <= nxt;
        end
    end

endmodule

// File: rtl/lcd_scan_cnt.sv
// Clock-in-line and line-in-frame counters; line length follows the gaps.
// Assumes the gap pair changes only together with the frame wrap.
module lcd_scan_cnt
    import lcd_tc_pkg::*;
#(
    parameter int H_SYNC   = 96,
    parameter int H_ACTIVE = 640,
    parameter int V_TOTAL  = 525,
    parameter int HW       = 10,
    parameter int VW       = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  porch_t        porch_i,
    output logic [HW-1:0] hcnt_o,
    output logic [VW-1:0] vcnt_o,
    output logic          frame_wrap_o
);

    logic [HW-1:0] line_last;
    logic          line_end;
    logic          frame_end;

    // Purpose: find the last clock of the line and of the frame.
    always_comb begin
        line_last    = HW'(H_SYNC + H_ACTIVE - 1) + HW'(porch_i.lead) + HW'(porch_i.tail);
        line_end     = (hcnt_o == line_last);
        frame_end    = (vcnt_o == VW'(V_TOTAL - 1));
        frame_wrap_o = line_end && frame_end;
    end

    // Purpose: advance the raster position by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt_o <= '0;
            vcnt_o <= '0;
        end else if (line_end) begin
            hcnt_o <= '0;
            vcnt_o <= frame_end ? '0 : vcnt_o + VW'(1);
        end else begin
            hcnt_o <= hcnt_o + HW'(1);
        end
    end

endmodule

// File: rtl/lcd_out_stage.sv
// Decodes raster position into syncs, strobe and coordinates, gates pixel data,
// and registers every output in one stage so all of them align.
// Assumes pix_i belongs to the raster position presented this cycle.
module lcd_out_stage
    import lcd_tc_pkg::*;
#(
    parameter int H_SYNC   = 96,
    parameter int H_ACTIVE = 640,
    parameter int V_SYNC   = 2,
    parameter int V_BACK   = 33,
    parameter int V_ACTIVE = 480,
    parameter int HW       = 10,
    parameter int VW       = 10,
    parameter int CW       = 10,
    parameter int RW       = 9,
    parameter int PIX_W    = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  porch_t           porch_i,
    input  logic [HW-1:0]    hcnt_i,
    input  logic [VW-1:0]    vcnt_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic             hsync_n_o,
    output logic             vsync_n_o,
    output logic             de_o,
    output logic [CW-1:0]    col_o,
    output logic [RW-1:0]    row_o,
    output logic [PIX_W-1:0] rgb_o
);

    localparam int V_START = V_SYNC + V_BACK;
    localparam int V_STOP  = V_START + V_ACTIVE;

    logic [HW-1:0] h_start;
    logic [HW-1:0] h_stop;
    logic          show;

    // Purpose: decide whether this raster position is visible.
    always_comb begin
        h_start = HW'(H_SYNC) + HW'(porch_i.lead);
        h_stop  = h_start + HW'(H_ACTIVE);
        show    = (hcnt_i >= h_start) && (hcnt_i < h_stop) &&
                  (vcnt_i >= VW'(V_START)) && (vcnt_i < VW'(V_STOP));
    end

    // Purpose: register all panel-facing outputs together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_n_o <= 1'b1;
            vsync_n_o <= 1'b1;
            de_o      <= 1'b0;
            col_o     <= '0;
            row_o     <= '0;
            rgb_o     <= '0;
        end else begin
            hsync_n_o <= !(hcnt_i < HW'(H_SYNC));
            vsync_n_o <= !(vcnt_i < VW'(V_SYNC));
            de_o      <= show;
            col_o     <= show ? CW'(hcnt_i - h_start) : '0;
            row_o     <= show ? RW'(vcnt_i - VW'(V_START)) : '0;
            rgb_o     <= show ? pix_i : '0;
        end
    end

endmodule

// File: rtl/lcd_timing_ctrl.sv
// Top of the panel scan timing generator: setting capture, raster counters
// and the aligned output stage. Assumes a raster-order pixel source.
module lcd_timing_ctrl
    import lcd_tc_pkg::*;
#(
    parameter int H_SYNC   = 96,
    parameter int H_ACTIVE = 640,
    parameter int V_SYNC   = 2,
    parameter int V_BACK   = 33,
    parameter int V_ACTIVE = 480,
    parameter int V_FRONT  = 10,
    parameter int CH_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_en_i,
    input  logic [LEAD_W-1:0]    lead_i,
    input  logic [TAIL_W-1:0]    tail_i,
    input  logic [3*CH_W-1:0]    pix_i,
    output logic                 hsync_n_o,
    output logic                 vsync_n_o,
    output logic                 de_o,
    output logic [$clog2(H_ACTIVE)-1:0] col_o,
    output logic [$clog2(V_ACTIVE)-1:0] row_o,
    output logic [3*CH_W-1:0]    rgb_o
);

    localparam int PIX_W   = 3 * CH_W;
    localparam int V_TOTAL = V_SYNC + V_BACK + V_ACTIVE + V_FRONT;
    localparam int H_MAX   = H_SYNC + LEAD_MAX + H_ACTIVE + TAIL_MAX;
    localparam int HW      = $clog2(H_MAX);
    localparam int VW      = $clog2(V_TOTAL);
    localparam int CW      = $clog2(H_ACTIVE);
    localparam int RW      = $clog2(V_ACTIVE);

    porch_t        porch;
    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          frame_wrap;

    lcd_cfg_shadow u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_wrap),
        .mode_en_i (mode_en_i),
        .lead_i    (lead_i),
        .tail_i    (tail_i),
        .porch_o   (porch)
    );

    lcd_scan_cnt #(
        .H_SYNC   (H_SYNC),
        .H_ACTIVE (H_ACTIVE),
        .V_TOTAL  (V_TOTAL),
        .HW       (HW),
        .VW       (VW)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .porch_i      (porch),
        .hcnt_o       (hcnt),
        .vcnt_o       (vcnt),
        .frame_wrap_o (frame_wrap)
    );

    lcd_out_stage #(
        .H_SYNC   (H_SYNC),
        .H_ACTIVE (H_ACTIVE),
        .V_SYNC   (V_SYNC),
        .V_BACK   (V_BACK),
        .V_ACTIVE (V_ACTIVE),
        .HW       (HW),
        .VW       (VW),
        .CW       (CW),
        .RW       (RW),
        .PIX_W    (PIX_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .porch_i   (porch),
        .hcnt_i    (hcnt),
        .vcnt_i    (vcnt),
        .pix_i     (pix_i),
        .hsync_n_o (hsync_n_o),
        .vsync_n_o (vsync_n_o),
        .de_o      (de_o),
        .col_o     (col_o),
        .row_o     (row_o),
        .rgb_o     (rgb_o)
    );

endmodule

// File: rtl/lcd_timing_chk.sv
// Property checker for the scan timing generator, bound to the top module.
// Assumes synchronous active-low reset; window lengths use counters.
module lcd_timing_chk
    import lcd_tc_pkg::*;
#(
    parameter int H_SYNC   = 96,
    parameter int H_ACTIVE = 640,
    parameter int CW       = 10,
    parameter int PIX_W    = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsync_n_o,
    input logic             vsync_n_o,
    input logic             de_o,
    input logic [CW-1:0]    col_o,
    input logic [PIX_W-1:0] rgb_o,
    input logic             frame_wrap,
    input porch_t           porch
);

    logic armed;
    int   hs_low;
    int   de_high;

    // Purpose: enable past-looking checks only after a clean post-reset cycle.
    always_ff @(posedge clk) armed <= rst_n;

    // Purpose: measure line sync and strobe run lengths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_low  <= 0;
            de_high <= 0;
        end else begin
            hs_low  <= hsync_n_o ? 0 : hs_low + 1;
            de_high <= de_o ? de_high + 1 : 0;
        end
    end

    AST_HSYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $rose(hsync_n_o) |-> hs_low == H_SYNC); // R2
    AST_VSYNC_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($fell(vsync_n_o) || $rose(vsync_n_o)) |-> $fell(hsync_n_o)); // R3
    AST_DE_RUN: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $fell(de_o) |-> de_high == H_ACTIVE); // R4
    AST_GAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        porch.lead >= LEAD_W'(LEAD_MIN) && porch.lead <= LEAD_W'(LEAD_MAX) &&
        porch.tail >= TAIL_W'(TAIL_MIN) && porch.tail <= TAIL_W'(TAIL_MAX)); // R6
    AST_DE_NOT_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (hsync_n_o && vsync_n_o)); // R7
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !de_o |-> rgb_o == '0); // R8
    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (de_o && $past(de_o)) |-> col_o == $past(col_o) + CW'(1)); // R9
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !frame_wrap |=> $stable(porch)); // R10

endmodule

bind lcd_timing_ctrl lcd_timing_chk #(
    .H_SYNC   (H_SYNC),
    .H_ACTIVE (H_ACTIVE),
    .CW       (CW),
    .PIX_W    (PIX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsync_n_o  (hsync_n_o),
    .vsync_n_o  (vsync_n_o),
    .de_o       (de_o),
    .col_o      (col_o),
    .rgb_o      (rgb_o),
    .frame_wrap (frame_wrap),
    .porch      (porch)
);

// File: tb/tb_lcd_timing_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural raster model compared against every output on every clock.
module tb_lcd_timing_ctrl;

    localparam int HS = 96;
    localparam int HA = 640;
    localparam int VS = 2;
    localparam int VB = 3;
    localparam int VA = 4;
    localparam int VF = 2;
    localparam int VT = VS + VB + VA + VF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_en_i;
    logic [5:0]  lead_i;
    logic [4:0]  tail_i;
    logic [17:0] pix_i;
    logic        hsync_n_o, vsync_n_o, de_o;
    logic [9:0]  col_o;
    logic [1:0]  row_o;
    logic [17:0] rgb_o;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit finished = 0;

    // model state
    int m_h, m_v, m_lead, m_tail, m_mode_raw, m_lead_raw, m_tail_raw;
    bit m_mode, m_clamped, in_rst;
    int e_hs, e_vs, e_de, e_col, e_row, e_rgb;
    string de_tag;

    always #4 clk = ~clk;

    lcd_timing_ctrl #(
        .H_SYNC(HS), .H_ACTIVE(HA), .V_SYNC(VS), .V_BACK(VB),
        .V_ACTIVE(VA), .V_FRONT(VF), .CH_W(6)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mode_en_i(mode_en_i), .lead_i(lead_i),
        .tail_i(tail_i), .pix_i(pix_i), .hsync_n_o(hsync_n_o),
        .vsync_n_o(vsync_n_o), .de_o(de_o), .col_o(col_o), .row_o(row_o),
        .rgb_o(rgb_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual=%0d expected=%0d", tag, what, $time, act, exp);
        end
    endtask

    task automatic capture_cfg();
        m_mode_raw = int'(mode_en_i);
        m_lead_raw = int'(lead_i);
        m_tail_raw = int'(tail_i);
        m_mode     = mode_en_i;
        if (mode_en_i) begin
            m_lead = (m_lead_raw < 4) ? 4 : (m_lead_raw > 48) ? 48 : m_lead_raw;
            m_tail = (m_tail_raw < 2) ? 2 : (m_tail_raw > 16) ? 16 : m_tail_raw;
            m_clamped = (m_lead != m_lead_raw) || (m_tail != m_tail_raw);
        end else begin
            m_lead = 48;
            m_tail = 16;
            m_clamped = 0;
        end
    endtask

    // Reference model: predicts outputs registered at this edge.
    always @(posedge clk) begin
        bit vis_row, vis;
        bit pending;
        if (!rst_n) begin
            in_rst = 1;
            m_h = 0; m_v = 0;
            capture_cfg();
            e_hs = 1; e_vs = 1; e_de = 0; e_col = 0; e_row = 0; e_rgb = 0;
        end else begin
            in_rst  = 0;
            vis_row = (m_v >= VS + VB) && (m_v < VS + VB + VA);
            vis     = vis_row && (m_h >= HS + m_lead) && (m_h < HS + m_lead + HA);
            pending = (int'(mode_en_i) != m_mode_raw) || (int'(lead_i) != m_lead_raw) ||
                      (int'(tail_i) != m_tail_raw);
            e_hs  = (m_h < HS) ? 0 : 1;
            e_vs  = (m_v < VS) ? 0 : 1;
            e_de  = vis ? 1 : 0;
            e_col = vis ? m_h - HS - m_lead : 0;
            e_row = vis ? m_v - VS - VB : 0;
            e_rgb = vis ? int'(pix_i) : 0;
            if (!vis_row)       de_tag = "R7";
            else if (pending)   de_tag = "R10";
            else if (!m_mode)   de_tag = "R4";
            else if (m_clamped) de_tag = "R6";
            else                de_tag = "R5";
            if (m_h == HS + m_lead + HA + m_tail - 1) begin
                m_h = 0;
                if (m_v == VT - 1) begin
                    m_v = 0;
                    capture_cfg();
                end else begin
                    m_v++;
                end
            end else begin
                m_h++;
            end
        end
        started = 1;
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            check(in_rst ? "R1" : "R2", "hsync_n", int'(hsync_n_o), e_hs);
            check(in_rst ? "R1" : "R3", "vsync_n", int'(vsync_n_o), e_vs);
            check(in_rst ? "R1" : de_tag, "de", int'(de_o), e_de);
            check(in_rst ? "R1" : "R9", "col", int'(col_o), e_col);
            check(in_rst ? "R1" : "R9", "row", int'(row_o), e_row);
            check(in_rst ? "R1" : "R8", "rgb", int'(rgb_o), e_rgb);
        end
    end

    // Pixel source: a changing pattern on every falling edge.
    always @(negedge clk) begin
        if (!finished) pix_i <= pix_i + 18'h01_0C5;
    end

    task automatic next_frame();
        @(negedge vsync_n_o);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        mode_en_i = 1'b0;
        lead_i = 6'd20;
        tail_i = 5'd5;
        pix_i = 18'h2A5_5A;
        repeat (3) @(negedge clk);
        // R1: explicit reset-state check
        check("R1", "reset hsync_n", int'(hsync_n_o), 1);
        check("R1", "reset de", int'(de_o), 0);
        rst_n = 1'b1;
        // Frame 1: fixed mode; settings change mid frame (R10)
        next_frame();
        repeat (3000) @(negedge clk);
        mode_en_i = 1'b1; lead_i = 6'd10; tail_i = 5'd3;
        // Frame 2: strobe mode, in-range gaps (R5); then out-of-range high lead, zero tail
        next_frame();
        repeat (3000) @(negedge clk);
        lead_i = 6'd60; tail_i = 5'd0;
        // Frame 3: clamped to 48 and 2 (R6)
        next_frame();
        repeat (3000) @(negedge clk);
        lead_i = 6'd1; tail_i = 5'd31;
        // Frame 4: clamped to 4 and 16 (R6)
        next_frame();
        repeat (3000) @(negedge clk);
        mode_en_i = 1'b0;
        // Frame 5: back to fixed mode (R4)
        next_frame();
        next_frame();
        repeat (200) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog R1..all: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule